// File: doc/BRIEF.md
# Low-Latency Dual-Chain Systolic GF(2^m) Multiplier

This block multiplies two elements of the binary extension field GF(2^m), both written in polynomial basis. The field degree `DEG`, which must be even, and the low coefficients of the irreducible polynomial f(x) are parameters. The block is fully pipelined. It accepts one operand pair on every clock in which `in_vld_i` is high and returns the reduced product a·b mod f a fixed number of cycles later. No stall is ever needed.

The shift-and-add recurrence is split across two interleaved chains of H = DEG/2 systolic stages each. The first chain handles the even-index bits of b and the second handles the odd-index bits.

- An entry stage registers a for the even chain and a·x mod f for the odd chain.
- Each forwarding stage ANDs its operand with its own b bit and XORs the result into a running partial sum. It also passes operand·x² mod f on to the next stage of its chain.
- The last stage of each chain only ANDs and XORs.
- A final register XORs the two partial sums together.

The b bits are skewed by per-pair delay lines, so each stage meets the b bit that belongs to its own operand pair. Every stage holds at most two reductions in series, so the stage critical path is two XOR delays. The parameter `SHARE_RED` selects a variant in which the even and odd halves of a stage share one reduction result.

Top module: `gfm_dual_mult`

## Requirements
- R1: For every accepted pair, `prod_o` equals a·b reduced modulo f. With the defaults, f = x^8+x^4+x^3+x+1 and `POLY` = 8'h1B, where bit i of `POLY` is the coefficient of x^i and bit 0 is always 1.
- R2: The result of a pair sampled on a rising edge with `in_vld_i` high appears with `prod_vld_o` high exactly DEG/2+2 clock cycles after that pair was presented. This is 6 cycles for the defaults.
- R3: The odd chain starts from a·x mod f. A pair whose b has only bit 1 set yields a·x mod f.
- R4: A b bit that is zero leaves the partial sum of its stage unchanged. A b with only bit i set yields a·x^i mod f for every i from 0 to DEG-1.
- R5: Pairs presented on consecutive cycles produce results on consecutive cycles, in the order they were presented.
- R6: A synchronous active-high `rst` clears every pipeline register. Pairs still in flight when `rst` is asserted never produce a valid result.
- R7: `prod_o` reads zero in every cycle where `prod_vld_o` is low.
- R8: The operand values zero, one, all-ones and the top bit alone give correct products in every pairing.
- R9: With `SHARE_RED` = 1, the products and the latency are identical to those with `SHARE_RED` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld_i | input | 1 | Operand pair valid |
| a_i | input | DEG | Operand a, bit i is the coefficient of x^i |
| b_i | input | DEG | Operand b, bit i is the coefficient of x^i |
| prod_vld_o | output | 1 | Product valid |
| prod_o | output | DEG | Product a·b mod f, zero when not valid |

## Verification
Several properties are checked on every cycle:
- The entry stage hands a unchanged to the even chain and hands the odd chain a word whose bit 0 is the top bit of a.
- A zero b bit lets a partial sum pass unchanged.
- No valid result appears before DEG/2+2 cycles have elapsed since reset.
- The product is zero whenever it is not valid.

Other behaviours are shown only by the bench's scenarios:
- Arithmetic correctness against a shift-and-add reference.
- The exact latency.
- Ordering under back-to-back traffic.
- The loss of in-flight pairs at reset.
- The equivalence of the shared-reduction variant.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    // Pipeline depth: entry stage, DEG/2 chain stages, final adder.
    function automatic int gfm_latency(input int deg);
        return deg / 2 + 2;
    endfunction

    // Width of a counter that can hold the value n.
    function automatic int gfm_cnt_w(input int n);
        return $clog2(n + 1) + 1;
    endfunction

endpackage

// File: rtl/gfm_bskew.sv
// Per-pair delay lines: pair j of b (bits 2j+1:2j) is delayed j+1 cycles.
module gfm_bskew #(
    parameter int DEG = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DEG-1:0] b_i,
    output logic [DEG-1:0] b_dly_o
);
    localparam int H = DEG / 2;

    for (genvar j = 0; j < H; j++) begin : g_pair
        logic [2*(j+1)-1:0] sr_q;
        if (j == 0) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= b_i[1:0];
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[2*j-1:0], b_i[2*j+1:2*j]};
            end
        end
        assign b_dly_o[2*j+1:2*j] = sr_q[2*j+1:2*j];
    end
endmodule

// File: rtl/gfm_pre.sv
// Entry stage: a goes to the even chain, a*x mod f to the odd chain.
module gfm_pre #(
    parameter int             M    = 8,
    parameter logic [M-1:0]   POLY = 8'h1B
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [M-1:0] a_i,
    output logic         vld_o,
    output logic [M-1:0] ev_op_o,
    output logic [M-1:0] od_op_o
);
    function automatic logic [M-1:0] red1(input logic [M-1:0] v);
        return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o   <= 1'b0;
            ev_op_o <= '0;
            od_op_o <= '0;
        end else begin
            vld_o   <= vld_i;
            ev_op_o <= a_i;
            od_op_o <= red1(a_i);
        end
    end

    assert_pre_split_R3: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> (ev_op_o == $past(a_i)) && (od_op_o[0] == $past(a_i[M-1])));
endmodule

// File: rtl/gfm_stage.sv
// Forwarding stage of both chains: AND/XOR into the partial sums, x^2 step on operands.
module gfm_stage #(
    parameter int           M     = 8,
    parameter logic [M-1:0] POLY  = 8'h1B,
    parameter bit           SHARE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [M-1:0] ev_op_i,
    input  logic [M-1:0] od_op_i,
    input  logic [M-1:0] ev_sum_i,
    input  logic [M-1:0] od_sum_i,
    input  logic [1:0]   bp_i,
    output logic         vld_o,
    output logic [M-1:0] ev_op_o,
    output logic [M-1:0] od_op_o,
    output logic [M-1:0] ev_sum_o,
    output logic [M-1:0] od_sum_o
);
    function automatic logic [M-1:0] red1(input logic [M-1:0] v);
        return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
    endfunction

    logic [M-1:0] ev_nxt, od_nxt;

    if (SHARE) begin : g_shared
        logic [M-1:0] mid;
        always_comb begin
            mid    = red1(od_op_i);
            ev_nxt = mid;
            od_nxt = red1(mid);
        end
    end else begin : g_split
        always_comb begin
            ev_nxt = red1(red1(ev_op_i));
            od_nxt = red1(red1(od_op_i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            ev_op_o  <= '0;
            od_op_o  <= '0;
            ev_sum_o <= '0;
            od_sum_o <= '0;
        end else begin
            vld_o    <= vld_i;
            ev_op_o  <= ev_nxt;
            od_op_o  <= od_nxt;
            ev_sum_o <= ev_sum_i ^ (ev_op_i & {M{bp_i[0]}});
            od_sum_o <= od_sum_i ^ (od_op_i & {M{bp_i[1]}});
        end
    end

    assert_zero_bit_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !bp_i[0]) |=> ev_sum_o == $past(ev_sum_i));
    assert_zero_bit_pass_odd_R4: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !bp_i[1]) |=> od_sum_o == $past(od_sum_i));
endmodule

// File: rtl/gfm_tail.sv
// Last stage of both chains: AND/XOR only, no reduction.
module gfm_tail #(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [M-1:0] ev_op_i,
    input  logic [M-1:0] od_op_i,
    input  logic [M-1:0] ev_sum_i,
    input  logic [M-1:0] od_sum_i,
    input  logic [1:0]   bp_i,
    output logic         vld_o,
    output logic [M-1:0] ev_sum_o,
    output logic [M-1:0] od_sum_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            ev_sum_o <= '0;
            od_sum_o <= '0;
        end else begin
            vld_o    <= vld_i;
            ev_sum_o <= ev_sum_i ^ (ev_op_i & {M{bp_i[0]}});
            od_sum_o <= od_sum_i ^ (od_op_i & {M{bp_i[1]}});
        end
    end

    assert_tail_zero_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !bp_i[0] && !bp_i[1]) |=>
            (ev_sum_o == $past(ev_sum_i)) && (od_sum_o == $past(od_sum_i)));
endmodule

// File: rtl/gfm_dual_mult.sv
module gfm_dual_mult #(
    parameter int             DEG       = 8,
    parameter logic [DEG-1:0] POLY      = 8'h1B,
    parameter bit             SHARE_RED = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld_i,
    input  logic [DEG-1:0] a_i,
    input  logic [DEG-1:0] b_i,
    output logic           prod_vld_o,
    output logic [DEG-1:0] prod_o
);
    import gfm_pkg::*;

    localparam int H   = DEG / 2;
    localparam int LAT = gfm_latency(DEG);
    localparam int CW  = gfm_cnt_w(LAT);
    localparam logic [CW-1:0] LAT_C = CW'(LAT);

    logic [DEG-1:0] b_dly;
    logic           vld_w    [0:H-1];
    logic [DEG-1:0] ev_op_w  [0:H-1];
    logic [DEG-1:0] od_op_w  [0:H-1];
    logic [DEG-1:0] ev_sum_w [0:H-1];
    logic [DEG-1:0] od_sum_w [0:H-1];
    logic           tail_vld;
    logic [DEG-1:0] tail_ev, tail_od;

    gfm_bskew #(.DEG(DEG)) u_skew (
        .clk(clk), .rst(rst), .b_i(b_i), .b_dly_o(b_dly)
    );

    gfm_pre #(.M(DEG), .POLY(POLY)) u_pre (
        .clk(clk), .rst(rst), .vld_i(in_vld_i), .a_i(a_i),
        .vld_o(vld_w[0]), .ev_op_o(ev_op_w[0]), .od_op_o(od_op_w[0])
    );

    // First stage of each chain has no incoming partial sum.
    assign ev_sum_w[0] = '0;
    assign od_sum_w[0] = '0;

    for (genvar k = 0; k < H - 1; k++) begin : g_stg
        gfm_stage #(.M(DEG), .POLY(POLY), .SHARE(SHARE_RED)) u_stg (
            .clk(clk), .rst(rst), .vld_i(vld_w[k]),
            .ev_op_i(ev_op_w[k]), .od_op_i(od_op_w[k]),
            .ev_sum_i(ev_sum_w[k]), .od_sum_i(od_sum_w[k]),
            .bp_i(b_dly[2*k+1:2*k]),
            .vld_o(vld_w[k+1]),
            .ev_op_o(ev_op_w[k+1]), .od_op_o(od_op_w[k+1]),
            .ev_sum_o(ev_sum_w[k+1]), .od_sum_o(od_sum_w[k+1])
        );
    end

    gfm_tail #(.M(DEG)) u_tail (
        .clk(clk), .rst(rst), .vld_i(vld_w[H-1]),
        .ev_op_i(ev_op_w[H-1]), .od_op_i(od_op_w[H-1]),
        .ev_sum_i(ev_sum_w[H-1]), .od_sum_i(od_sum_w[H-1]),
        .bp_i(b_dly[DEG-1:DEG-2]),
        .vld_o(tail_vld), .ev_sum_o(tail_ev), .od_sum_o(tail_od)
    );

    // Final adder: joins the two chains, zero on idle cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_vld_o <= 1'b0;
            prod_o     <= '0;
        end else begin
            prod_vld_o <= tail_vld;
            prod_o     <= tail_vld ? (tail_ev ^ tail_od) : '0;
        end
    end

    // Cycles since reset, saturating at the pipeline depth.
    logic [CW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                 since_q <= '0;
        else if (since_q < LAT_C) since_q <= since_q + 1'b1;
    end

    assert_latency_floor_R2: assert property (@(posedge clk) disable iff (rst)
        prod_vld_o |-> since_q >= LAT_C);
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !prod_vld_o |-> prod_o == '0);
endmodule

// File: tb/gfm_dual_mult_tb.sv
module gfm_dual_mult_tb_top;
    localparam int           M    = 8;
    localparam logic [M-1:0] POLY = 8'h1B;
    localparam int           LAT  = M / 2 + 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [M-1:0] in_a = '0, in_b = '0;
    logic         out_vld, shr_vld;
    logic [M-1:0] out_p, shr_p;
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    gfm_dual_mult #(.DEG(M), .POLY(POLY), .SHARE_RED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .in_vld_i(in_vld), .a_i(in_a), .b_i(in_b),
        .prod_vld_o(out_vld), .prod_o(out_p));
    gfm_dual_mult #(.DEG(M), .POLY(POLY), .SHARE_RED(1'b1)) dut_shr_i (
        .clk(clk), .rst(rst), .in_vld_i(in_vld), .a_i(in_a), .b_i(in_b),
        .prod_vld_o(shr_vld), .prod_o(shr_p));

    function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
        return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
    endfunction

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = xtime(r);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // Expected-output pipe built from the requirements (R1, R2, R6, R7).
    logic         mdl_v [0:LAT-1];
    logic [M-1:0] mdl_p [0:LAT-1];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                mdl_v[i] <= 1'b0;
                mdl_p[i] <= '0;
            end
        end else begin
            mdl_v[0] <= in_vld;
            mdl_p[0] <= in_vld ? ref_mul(in_a, in_b) : '0;
            for (int i = 1; i < LAT; i++) begin
                mdl_v[i] <= mdl_v[i-1];
                mdl_p[i] <= mdl_p[i-1];
            end
        end
    end

    task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [M-1:0] a, input logic [M-1:0] b,
                        input string req);
        in_vld = v; in_a = a; in_b = b;
        @(posedge clk); @(negedge clk);
        chk({req, " vld"}, M'(out_vld), M'(mdl_v[LAT-1]));
        chk({req, " prod"}, out_p, mdl_p[LAT-1]);
        chk({req, " share R9 vld"}, M'(shr_vld), M'(mdl_v[LAT-1]));
        chk({req, " share R9 prod"}, shr_p, mdl_p[LAT-1]);
    endtask

    task automatic flush(input string req);
        for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, req);
    endtask

    task automatic t_reset_state;
        chk("R6 reset vld", M'(out_vld), '0);
        chk("R6 reset prod", out_p, '0);
        rst = 1'b0;
        flush("R7 idle after reset");
    endtask

    task automatic t_latency;
        int n;
        in_vld = 1'b1; in_a = 8'h53; in_b = 8'hCA;
        @(posedge clk); @(negedge clk);
        in_vld = 1'b0;
        n = 1;
        while (!out_vld && n < 20) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        chk("R2 latency cycles", M'(n), M'(LAT));
        chk("R1 latency pair value", out_p, ref_mul(8'h53, 8'hCA));
        chk("R9 share latency", M'(shr_vld), 8'd1);
        flush("R2 drain");
    endtask

    task automatic t_single_bits;
        for (int i = 0; i < M; i++) step(1'b1, 8'hA7, M'(1) << i, "R4 single b bit");
        step(1'b1, 8'h80, 8'h02, "R3 odd chain a*x");
        step(1'b1, 8'h35, 8'h02, "R3 odd chain a*x");
        flush("R4 drain");
    endtask

    task automatic t_corners;
        logic [M-1:0] c [0:3];
        c[0] = 8'h00; c[1] = 8'h01; c[2] = 8'hFF; c[3] = 8'h80;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                step(1'b1, c[i], c[j], "R8 corner operands");
        flush("R8 drain");
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++)
            step(1'b1, M'($urandom), M'($urandom), "R1 R5 back-to-back random");
        flush("R5 drain");
    endtask

    task automatic t_bubbles;
        for (int i = 0; i < 40; i++)
            step(i % 3 != 0, M'($urandom), M'($urandom), "R7 bubbles");
        flush("R7 drain");
    endtask

    task automatic t_mid_reset;
        for (int i = 0; i < 3; i++) step(1'b1, M'(i + 9), 8'h3C, "R6 before reset");
        rst = 1'b1;
        step(1'b1, 8'h11, 8'h22, "R6 during reset");
        chk("R6 sync clear vld", M'(out_vld), '0);
        rst = 1'b0;
        flush("R6 in-flight dropped");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_state();
        t_latency();
        t_single_bits();
        t_corners();
        t_random();
        t_bubbles();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule